// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block sits between a four-wire serial bus and a 1024-byte nonvolatile storage array. An external bus master lowers chip select, clocks in a one-byte instruction, optionally a two-byte address and data, and reads back array or status bytes. All serial inputs are sampled by a fast system clock, so the serial clock is treated as data and its edges are found by comparing it with its value one system cycle earlier.

Decoded work leaves the block as single-cycle byte requests. Reads ask the array for one byte at a time; write bytes are handed to a page unit as staged bytes and then either committed or aborted when the frame closes. Status writes and write-enable changes go to a separate status and protection unit. The bus may be paused with a hold input without ending the frame. Power-on detection is outside the block and appears as `rst_n`.

The controller is one state machine. ST_IDLE (deselected) goes to ST_OPCODE on a chip-select falling edge. ST_OPCODE, after eight bits, goes to ST_ADDR for a read or write, to ST_RD_STAT for a status read, to ST_SR_DATA for a status write, to ST_WAIT_CS for write-enable set or clear, and to ST_IGNORE for any other code. ST_ADDR goes to ST_RD_DATA or ST_WR_DATA after the second address byte. ST_SR_DATA goes to ST_WAIT_CS after its data byte. ST_WAIT_CS goes to ST_IGNORE on any further clock rise. Every state except ST_IDLE returns to ST_IDLE as soon as chip select is high.

Top module: `spimem_slave`

## Requirements
- R1: Incoming bits are taken on rising edges of `sclk`, most significant bit first. Instruction codes: 0x01 status write, 0x02 array write, 0x03 array read, 0x04 write-enable clear, 0x05 status read, 0x06 write-enable set. Reads and writes carry a 16-bit address after the code, high byte first.
- R2: Outgoing bits change on falling edges of `sclk`, most significant bit first. `miso_oe` is 1 only while chip select is low, the bus is not held, and the frame is in a data-read or status-read phase; it is 0 whenever `cs_n` is high.
- R3: Frames work identically whether `sclk` idles low (mode 0) or high (mode 3).
- R4: After reset the block stays deselected while `cs_n` is low; it becomes selected only after a high-to-low transition of `cs_n`.
- R5: An instruction code outside the set of R1 deselects the block internally: `miso_oe` stays 0 and no request leaves the block until `cs_n` rises.
- R6: A read uses the low 10 address bits (upper bits ignored), requests one array byte per output byte (`mem_rd_en` pulse with `mem_addr`, data expected on `mem_rd_data` one cycle later), and increments the address after each byte, wrapping from 0x3FF to 0x000.
- R7: A status read returns `stat_in` as it stands at the last clock rise of the instruction and again at the last rise of each returned byte, for as long as clocking continues.
- R8: Each complete write data byte produces one `wr_stage_vld` pulse with its byte and address (incrementing with 10-bit wrap). When `cs_n` rises, `wr_commit` pulses if at least one byte was staged and no partial byte was clocked; otherwise `wr_abort` pulses.
- R9: A status write pulses `stat_wr_en` with the data byte only when `cs_n` rises after exactly 16 clock rises; any other count drops it.
- R10: Write-enable set or clear pulses `wen_set` or `wen_clr` only when `cs_n` rises after exactly 8 clock rises.
- R11: Hold begins only while selected and `sclk` is low with `hold_n` low; a `hold_n` fall while `sclk` is high takes effect when `sclk` next goes low. During hold `miso_oe` is 0 and `sclk` and `mosi` are ignored; hold ends when `hold_n` is high and `sclk` is low.
- R12: A rising `cs_n` discards any partly received instruction; the next frame starts counting bits from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| sclk | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| miso | output | 1 | Serial data out value |
| miso_oe | output | 1 | Output enable for the serial data pad |
| mem_rd_en | output | 1 | One-cycle array read request |
| mem_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array read data, one cycle after the request |
| wr_stage_vld | output | 1 | One-cycle staged write byte strobe |
| wr_stage_addr | output | ADDR_W | Address of the staged byte |
| wr_stage_data | output | 8 | Staged write byte |
| wr_commit | output | 1 | Frame closed validly; program staged bytes |
| wr_abort | output | 1 | Frame closed invalidly; drop staged bytes |
| stat_in | input | 8 | Current status byte |
| stat_wr_en | output | 1 | One-cycle status write request |
| stat_wr_data | output | 8 | Status byte to write |
| wen_set | output | 1 | One-cycle write-enable set request |
| wen_clr | output | 1 | One-cycle write-enable clear request |

## Verification
A serial clock rise or fall is acted on at the first system edge that sees the new level, so clock-phase results such as the next `miso` bit appear one system cycle after the bus edge; the bench holds each serial level for four system cycles and samples `miso` just before the next rise. Array read data needs two system cycles after the address or byte boundary (request, then array response) before it is loaded for shifting, which the four-cycle half period covers. Frame-end pulses (`wr_commit`, `stat_wr_en`, `wen_set`, `wen_clr`) come one cycle after `cs_n` rises, and the bench reads its pulse counters eight cycles later; staged bytes come one cycle after the eighth rise and are logged by a monitor.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RD_DATA,
        ST_RD_STAT,
        ST_WR_DATA,
        ST_SR_DATA,
        ST_WAIT_CS,
        ST_IGNORE
    } spi_state_e;

    localparam logic [7:0] OP_SET_STAT = 8'h01;
    localparam logic [7:0] OP_WRITE    = 8'h02;
    localparam logic [7:0] OP_READ     = 8'h03;
    localparam logic [7:0] OP_WEN_CLR  = 8'h04;
    localparam logic [7:0] OP_GET_STAT = 8'h05;
    localparam logic [7:0] OP_WEN_SET  = 8'h06;

endpackage

// File: rtl/spimem_front.sv
// Edge finder for the serial clock and chip select, plus the pause tracker.
module spimem_front (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic hold_n,
    input  logic sel,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic held
);

    logic sclk_r;
    logic cs_r;
    logic hold_q;
    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_r <= 1'b0;
            cs_r   <= 1'b0;   // "seen low": a chip select held low from reset gives no fall
            hold_q <= 1'b0;
        end else begin
            sclk_r <= sclk;
            cs_r   <= cs_n;
            if (!sel || cs_n)
                hold_q <= 1'b0;
            else if (!sclk)
                hold_q <= !hold_n;
        end
    end

    assign live      = sel && !cs_n && !hold_q;
    assign sclk_rise = live && sclk && !sclk_r;
    assign sclk_fall = live && !sclk && sclk_r;
    assign cs_fall   = !cs_n && cs_r;
    assign cs_rise   = cs_n && !cs_r;
    assign held      = hold_q;

    // R11: pause can only begin on a cycle where the serial clock was low
    p_hold_low_clk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> !$past(sclk));

    // R11: pause never survives deselection
    p_hold_needs_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> $past(sel) && !$past(cs_n));

endmodule

// File: rtl/spimem_tx.sv
// Output byte register and bit selector for the serial data out line.
module spimem_tx #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [W-1:0]         load_data,
    input  logic                 shift_en,
    input  logic [$clog2(W)-1:0] bit_idx,
    output logic                 miso
);

    localparam int IW = $clog2(W);

    logic [W-1:0]  ob;
    logic          miso_q;
    logic [IW-1:0] pick;

    assign pick = IW'(W - 1) - bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob     <= '0;
            miso_q <= 1'b0;
        end else begin
            if (load_en)
                ob <= load_data;
            if (shift_en)
                miso_q <= ob[pick];
        end
    end

    assign miso = miso_q;

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
    import spimem_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int ADDR_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              hold_n,
    output logic              miso,
    output logic              miso_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              wr_stage_vld,
    output logic [ADDR_W-1:0] wr_stage_addr,
    output logic [7:0]        wr_stage_data,
    output logic              wr_commit,
    output logic              wr_abort,
    input  logic [7:0]        stat_in,
    output logic              stat_wr_en,
    output logic [7:0]        stat_wr_data,
    output logic              wen_set,
    output logic              wen_clr
);

    localparam int BYTE_W = 8;
    localparam int BC_W   = $clog2(BYTE_W);
    localparam int AC_W   = $clog2(ADDR_BYTES + 1);
    localparam logic [AC_W-1:0] LAST_AB  = AC_W'(ADDR_BYTES - 1);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    spi_state_e state, state_n;

    logic              sel, sclk_rise, sclk_fall, cs_fall, cs_rise, held;
    logic [BC_W-1:0]   bit_cnt;
    logic [AC_W-1:0]   ab_cnt;
    logic [7:0]        rx_sr, rx_next, cmd, sr_byte;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_any, ld_q;
    logic              byte_done, st_load, tx_load, tx_shift, reading;
    logic [7:0]        tx_data;

    assign sel       = (state != ST_IDLE);
    assign rx_next   = {rx_sr[6:0], mosi};
    assign byte_done = sclk_rise && (bit_cnt == LAST_BIT);
    assign reading   = (state == ST_RD_DATA) || (state == ST_RD_STAT);

    spimem_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .hold_n    (hold_n),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .held      (held)
    );

    assign st_load  = byte_done && (((state == ST_OPCODE) && (rx_next == OP_GET_STAT))
                                    || (state == ST_RD_STAT));
    assign tx_load  = ld_q || st_load;
    assign tx_data  = ld_q ? mem_rd_data : stat_in;
    assign tx_shift = sclk_fall && reading;

    spimem_tx #(.W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (tx_load),
        .load_data (tx_data),
        .shift_en  (tx_shift),
        .bit_idx   (bit_cnt),
        .miso      (miso)
    );

    assign miso_oe  = !cs_n && !held && reading;
    assign mem_addr = addr_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (state != ST_IDLE && cs_n) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) state_n = ST_OPCODE;
                ST_OPCODE: if (byte_done) begin
                    case (rx_next)
                        OP_READ, OP_WRITE:       state_n = ST_ADDR;
                        OP_GET_STAT:             state_n = ST_RD_STAT;
                        OP_SET_STAT:             state_n = ST_SR_DATA;
                        OP_WEN_SET, OP_WEN_CLR:  state_n = ST_WAIT_CS;
                        default:                 state_n = ST_IGNORE;
                    endcase
                end
                ST_ADDR:    if (byte_done && ab_cnt == LAST_AB)
                                state_n = (cmd == OP_READ) ? ST_RD_DATA : ST_WR_DATA;
                ST_SR_DATA: if (byte_done) state_n = ST_WAIT_CS;
                ST_WAIT_CS: if (sclk_rise) state_n = ST_IGNORE;
                ST_RD_DATA, ST_RD_STAT, ST_WR_DATA, ST_IGNORE: ;
                default:    state_n = ST_IDLE;
            endcase
        end
    end

    // Datapath and request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt       <= '0;
            ab_cnt        <= '0;
            rx_sr         <= '0;
            cmd           <= '0;
            sr_byte       <= '0;
            addr_q        <= '0;
            wr_any        <= 1'b0;
            ld_q          <= 1'b0;
            mem_rd_en     <= 1'b0;
            wr_stage_vld  <= 1'b0;
            wr_stage_addr <= '0;
            wr_stage_data <= '0;
            wr_commit     <= 1'b0;
            wr_abort      <= 1'b0;
            stat_wr_en    <= 1'b0;
            stat_wr_data  <= '0;
            wen_set       <= 1'b0;
            wen_clr       <= 1'b0;
        end else begin
            mem_rd_en    <= 1'b0;
            wr_stage_vld <= 1'b0;
            wr_commit    <= 1'b0;
            wr_abort     <= 1'b0;
            stat_wr_en   <= 1'b0;
            wen_set      <= 1'b0;
            wen_clr      <= 1'b0;
            ld_q         <= mem_rd_en;

            if (cs_fall && state == ST_IDLE) begin
                bit_cnt <= '0;
                ab_cnt  <= '0;
                wr_any  <= 1'b0;
            end

            if (sclk_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sr   <= rx_next;
            end

            if (byte_done) begin
                case (state)
                    ST_OPCODE: cmd <= rx_next;
                    ST_ADDR: begin
                        addr_q <= ADDR_W'({addr_q, rx_next});
                        ab_cnt <= ab_cnt + 1'b1;
                        if (ab_cnt == LAST_AB && cmd == OP_READ)
                            mem_rd_en <= 1'b1;
                    end
                    ST_RD_DATA: begin
                        addr_q    <= addr_q + 1'b1;
                        mem_rd_en <= 1'b1;
                    end
                    ST_WR_DATA: begin
                        wr_stage_vld  <= 1'b1;
                        wr_stage_addr <= addr_q;
                        wr_stage_data <= rx_next;
                        addr_q        <= addr_q + 1'b1;
                        wr_any        <= 1'b1;
                    end
                    ST_SR_DATA: sr_byte <= rx_next;
                    default: ;
                endcase
            end

            if (cs_rise) begin
                case (state)
                    ST_WR_DATA: begin
                        if (bit_cnt == '0 && wr_any) wr_commit <= 1'b1;
                        else                         wr_abort  <= 1'b1;
                    end
                    ST_WAIT_CS: begin
                        if (cmd == OP_SET_STAT) begin
                            stat_wr_en   <= 1'b1;
                            stat_wr_data <= sr_byte;
                        end
                        if (cmd == OP_WEN_SET) wen_set <= 1'b1;
                        if (cmd == OP_WEN_CLR) wen_clr <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: deselected means the data pad is released
    p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !miso_oe);

    // R4: leaving the deselected state requires a chip-select fall
    p_enter_needs_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) == ST_IDLE) |-> $past(cs_fall));

    // R5: a rejected frame stays silent
    p_ignore_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !miso_oe && !mem_rd_en && !wr_stage_vld);

    // R6: array reads only during the data-read phase
    p_rd_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (state == ST_RD_DATA));

    // R8: a commit follows a whole-byte close of a write frame
    p_commit_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(state) == ST_WR_DATA) && ($past(bit_cnt) == '0));

    // R8 R9 R10: at most one frame-end action per cycle
    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_commit, wr_abort, stat_wr_en, wen_set, wen_clr}));

    // R11: receive state frozen while paused
    p_rx_frozen_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable(bit_cnt) && $stable(rx_sr));

endmodule

// File: tb/spimem_slave_tb.sv
`timescale 1ns/1ps
module spimem_slave_tb;

    localparam int H = 4;
    localparam logic [7:0] C_SSTAT = 8'h01, C_WR = 8'h02, C_RD = 8'h03,
                           C_WCLR  = 8'h04, C_GSTAT = 8'h05, C_WSET = 8'h06;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n, sclk, cs_n, mosi, hold_n;
    logic       miso, miso_oe, mem_rd_en, wr_stage_vld, wr_commit, wr_abort;
    logic       stat_wr_en, wen_set, wen_clr;
    logic [9:0] mem_addr, wr_stage_addr;
    logic [7:0] mem_rd_data, wr_stage_data, stat_in, stat_wr_data;

    spimem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .hold_n(hold_n),
        .miso(miso), .miso_oe(miso_oe), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .wr_stage_vld(wr_stage_vld), .wr_stage_addr(wr_stage_addr),
        .wr_stage_data(wr_stage_data), .wr_commit(wr_commit), .wr_abort(wr_abort),
        .stat_in(stat_in), .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .wen_set(wen_set), .wen_clr(wen_clr)
    );

    // storage array model
    logic [7:0] mem [1024];
    initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 11) ^ 8'(i >> 3);
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

    // request monitor
    int n_stage = 0, n_commit = 0, n_abort = 0, n_swr = 0, n_wset = 0, n_wclr = 0;
    logic [7:0] last_swr = '0;
    logic [9:0] stg_a [256];
    logic [7:0] stg_d [256];
    always @(posedge clk) begin
        if (wr_stage_vld) begin
            stg_a[n_stage % 256] <= wr_stage_addr;
            stg_d[n_stage % 256] <= wr_stage_data;
            n_stage <= n_stage + 1;
        end
        if (wr_commit)  n_commit <= n_commit + 1;
        if (wr_abort)   n_abort  <= n_abort + 1;
        if (stat_wr_en) begin n_swr <= n_swr + 1; last_swr <= stat_wr_data; end
        if (wen_set)    n_wset   <= n_wset + 1;
        if (wen_clr)    n_wclr   <= n_wclr + 1;
    end

    int checks = 0, errors = 0;
    bit done = 0;
    bit m3 = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_nofall(input logic b, output logic q);
        mosi = b;
        tick(H);
        q = miso;
        sclk = 1'b1;
        tick(H);
    endtask

    task automatic bit_full(input logic b, output logic q);
        sclk = 1'b0;
        bit_nofall(b, q);
    endtask

    task automatic byte_x(input logic [7:0] d, output logic [7:0] q);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_full(d[i], b);
            q[i] = b;
        end
    endtask

    task automatic frame_start;
        sclk = m3;
        cs_n = 1'b1;
        tick(H);
        cs_n = 1'b0;
        tick(H);
    endtask

    task automatic frame_end;
        if (!m3) begin sclk = 1'b0; tick(H); end
        cs_n = 1'b1;
        tick(2 * H);
    endtask

    function automatic logic [7:0] exp_rd(input logic [15:0] a, input int i);
        return mem[10'(a[9:0] + 10'(i))];
    endfunction

    // R1 R6: read frame with auto-increment
    task automatic read_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] q;
        frame_start;
        byte_x(C_RD, q);
        byte_x(a[15:8], q);
        byte_x(a[7:0], q);
        for (int i = 0; i < n; i++) begin
            byte_x(8'($urandom), q);
            chk(q == exp_rd(a, i), req, q, exp_rd(a, i));
        end
        frame_end;
    endtask

    // R8: whole-byte write frame
    task automatic write_chk(input logic [15:0] a, input int n, input string req);
        logic [7:0] q;
        logic [7:0] d [8];
        int s, c;
        s = n_stage; c = n_commit;
        frame_start;
        byte_x(C_WR, q);
        byte_x(a[15:8], q);
        byte_x(a[7:0], q);
        for (int i = 0; i < n; i++) begin
            d[i] = 8'($urandom);
            byte_x(d[i], q);
        end
        frame_end;
        chk(n_stage - s == n, req, n_stage - s, n);
        chk(n_commit - c == 1, req, n_commit - c, 1);
        for (int i = 0; i < n; i++) begin
            chk(stg_a[(s + i) % 256] == 10'(a[9:0] + 10'(i)), req, stg_a[(s + i) % 256], 10'(a[9:0] + 10'(i)));
            chk(stg_d[(s + i) % 256] == d[i], req, stg_d[(s + i) % 256], d[i]);
        end
    endtask

    initial begin
        logic [7:0] q, q1;
        int k;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b0; mosi = 1'b0; hold_n = 1'b1; stat_in = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // reset state
        chk(miso_oe == 1'b0, "R2 reset oe", miso_oe, 0);
        chk(n_wset + n_stage + n_swr == 0, "R10 reset pulses", n_wset + n_stage + n_swr, 0);

        // R4: chip select already low after reset is not a selection
        byte_x(C_WSET, q);
        cs_n = 1'b1;
        tick(2 * H);
        chk(n_wset == 0, "R4 no fall no select", n_wset, 0);

        // R10: write-enable set and clear
        frame_start; byte_x(C_WSET, q); frame_end;
        chk(n_wset == 1, "R10 set", n_wset, 1);
        frame_start; byte_x(C_WCLR, q); frame_end;
        chk(n_wclr == 1, "R10 clear", n_wclr, 1);
        frame_start; byte_x(C_WSET, q); bit_full(1'b0, q[0]); frame_end;
        chk(n_wset == 1, "R10 nine bits dropped", n_wset, 1);

        // R7 R2: repeated status read, resampled per byte
        stat_in = 8'hA5;
        frame_start;
        byte_x(C_GSTAT, q);
        stat_in = 8'h3C;
        byte_x(8'h00, q);
        chk(q == 8'hA5, "R7 first status", q, 8'hA5);
        chk(miso_oe == 1'b1, "R2 oe in status read", miso_oe, 1);
        byte_x(8'h00, q);
        chk(q == 8'h3C, "R7 resampled status", q, 8'h3C);
        frame_end;
        chk(miso_oe == 1'b0, "R2 oe released", miso_oe, 0);

        // R6: reads, wrap and ignored upper address bits
        read_chk(16'h0123, 3, "R6 read");
        read_chk(16'hFFFF, 3, "R6 wrap upper bits");

        // R3: mode 3
        m3 = 1;
        read_chk(16'h02F1, 2, "R3 mode3 read");
        stat_in = 8'h96;
        frame_start; byte_x(C_GSTAT, q); byte_x(8'h00, q); frame_end;
        chk(q == 8'h96, "R3 mode3 status", q, 8'h96);
        m3 = 0;

        // R8: write with wrap, then write with a partial byte
        write_chk(16'h03FE, 3, "R8 write wrap");
        k = n_stage;
        frame_start;
        byte_x(C_WR, q); byte_x(8'h00, q); byte_x(8'h40, q);
        byte_x(8'h11, q); byte_x(8'h22, q);
        for (int i = 0; i < 3; i++) bit_full(1'b1, q[i]);
        frame_end;
        chk(n_stage - k == 2, "R8 partial staged", n_stage - k, 2);
        chk(n_abort == 1, "R8 partial aborts", n_abort, 1);
        chk(n_commit == 1, "R8 partial no commit", n_commit, 1);

        // R9: status write exact and with an extra bit
        frame_start; byte_x(C_SSTAT, q); byte_x(8'h8C, q); frame_end;
        chk(n_swr == 1 && last_swr == 8'h8C, "R9 status write", {n_swr[7:0], last_swr}, 16'h018C);
        frame_start; byte_x(C_SSTAT, q); byte_x(8'h0C, q); bit_full(1'b0, q[0]); frame_end;
        chk(n_swr == 1, "R9 extra bit dropped", n_swr, 1);

        // R5: unknown code deselects
        frame_start;
        byte_x(8'h0B, q);
        chk(miso_oe == 1'b0, "R5 oe after bad code", miso_oe, 0);
        byte_x(C_WSET, q); byte_x(C_RD, q);
        chk(miso_oe == 1'b0, "R5 oe stays off", miso_oe, 0);
        frame_end;
        chk(n_wset == 1, "R5 rest ignored", n_wset, 1);

        // R12: partial instruction discarded at chip-select rise
        frame_start;
        for (int i = 0; i < 4; i++) bit_full(1'b0, q[i]);
        frame_end;
        frame_start; byte_x(C_WSET, q); frame_end;
        chk(n_wset == 2, "R12 fresh frame", n_wset, 2);

        // R11: deferred hold entry, ignored clocks during hold
        frame_start;
        byte_x(C_RD, q); byte_x(8'h01, q); byte_x(8'h55, q);
        byte_x(8'h00, q);
        chk(q == mem[10'h155], "R11 pre-hold byte", q, mem[10'h155]);
        for (int i = 7; i >= 5; i--) begin logic b; bit_full(1'b0, b); q1[i] = b; end
        hold_n = 1'b0;
        tick(H);
        chk(miso_oe == 1'b1, "R11 hold deferred while clock high", miso_oe, 1);
        sclk = 1'b0;
        tick(H);
        chk(miso_oe == 1'b0, "R11 oe off in hold", miso_oe, 0);
        for (int j = 0; j < 3; j++) begin
            mosi = 1'($urandom); sclk = 1'b1; tick(H); sclk = 1'b0; tick(H);
        end
        hold_n = 1'b1;
        tick(H);
        chk(miso_oe == 1'b1, "R11 oe after release", miso_oe, 1);
        begin logic b; bit_nofall(1'b0, b); q1[4] = b; end
        for (int i = 3; i >= 0; i--) begin logic b; bit_full(1'b0, b); q1[i] = b; end
        chk(q1 == mem[10'h156], "R11 byte across hold", q1, mem[10'h156]);
        frame_end;

        // random mix, both modes
        for (int it = 0; it < 20; it++) begin
            m3 = 1'($urandom);
            if ($urandom % 2 == 0) read_chk(16'($urandom), 1 + int'($urandom % 4), "R1 R6 random read");
            else                   write_chk(16'($urandom), 1 + int'($urandom % 4), "R1 R8 random write");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule